// File: doc/BRIEF.md
# Floating-Point Control Register Access Unit

This unit serves the two control-register move operations of a scalar CPU's floating-point coprocessor: copying a control register into a general-purpose result, and copying a general-purpose operand into a control register. Each operation arrives as a single-cycle strobe with a direction flag, a 5-bit register index, the write operand and a flag saying whether the source general-purpose register index was zero. The unit answers with read data and a reserved-instruction fault pulse in the same cycle. Any state change lands on the following clock edge.

The unit owns two pieces of state. The first is the floating-point register mode bit (FR), which it exports to the register file. The second is a 32-bit control/status word that holds the condition codes. It also reads a fixed 32-bit implementation word and a configuration enable for user-mode FR switching. Index 1 is a user-mode alias that reads FR, or clears it on a write. Index 4 is a write-only alias that sets FR. Both aliases exist only when the implementation word advertises them. When they exist but the configuration enable is off, they fault.

Top module: `fpu_ctrl_access`

## Requirements
- R1: While reset is asserted, and after it is released, `fr_mode` is 0 and the condition-code word is 0, so a read of index 25 returns 0.
- R2: A read of index 0 returns `impl_reg` sign-extended from bit 31 to the full result width, with no fault.
- R3: A read of index 1, when `impl_reg` bit 28 (the user-FR-present bit) is 1 and `ufr_enable` is 1, returns FR in result bit 0. All other result bits are 0 and there is no fault.
- R4: A read of index 1, when the present bit is 1 and `ufr_enable` is 0, pulses `ri_exc` and returns 0.
- R5: A read of index 1, when the present bit is 0, returns 0 and raises no fault.
- R6: A write to index 1 clears FR, and a write to index 4 sets FR. This happens only when the present bit is 1, `src_is_zero` is 1 and `ufr_enable` is 1. `fr_mode` shows the new value from the clock edge that ends the strobe cycle.
- R7: A write to index 1 or index 4 with the present bit 0, or with `src_is_zero` 0, changes nothing and raises no fault.
- R8: A write to index 1 or index 4 with the present bit 1 and `src_is_zero` 1, but `ufr_enable` 0, pulses `ri_exc` and leaves FR unchanged.
- R9: A read of index 25 returns the condition codes packed into result bits 7..0. Word bits 31..25 appear in result bits 7..1, word bit 23 appears in result bit 0, and all higher result bits are 0.
- R10: A write to index 25 whose operand is 0 above bit 7 stores operand bits 7..1 into word bits 31..25 and operand bit 0 into word bit 23. All other word bits keep their values.
- R11: A write to index 25 whose operand has any bit set at position 8 or above is ignored entirely.
- R12: An operation on any index other than 0, 1, 4 or 25 returns 0, changes no state and raises no fault. Write operations always return 0.
- R13: `ri_exc` is high only in a cycle where `op_valid` is high. With `op_valid` low, the unit returns 0, raises no fault and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| op_valid | input | 1 | One-cycle strobe marking a control-register operation |
| op_write | input | 1 | 1 = move to control register, 0 = move from control register |
| op_index | input | 5 | Control register index |
| wr_data | input | XLEN (64) | Operand of a write |
| src_is_zero | input | 1 | The source general-purpose register index of a write is zero |
| impl_reg | input | 32 | Fixed implementation word; bit 28 advertises the user FR aliases |
| ufr_enable | input | 1 | Configuration enable for user-mode FR switching |
| rd_data | output | XLEN (64) | Read result, valid in the strobe cycle |
| ri_exc | output | 1 | Reserved-instruction fault, valid in the strobe cycle |
| fr_mode | output | 1 | Current FR mode bit, exported to the register file |

## Verification
`rd_data` and `ri_exc` are combinational from the operation inputs, so they are due in the strobe cycle itself. The bench drives each operation at a falling edge and samples these two outputs one nanosecond later, before the rising edge. `fr_mode` and the condition-code word are due after the rising edge that closes the strobe cycle. The bench samples `fr_mode` just after the following falling edge, and it observes the word through a later read of index 25. Reset release passes through a two-stage synchroniser, so the bench waits three cycles after deasserting `rst_n` before issuing the first operation.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

  localparam int unsigned IDX_W     = 5;
  localparam int unsigned IMPL_W    = 32;
  localparam int unsigned CSR_W     = 32;
  localparam int unsigned CC_HI     = 31;
  localparam int unsigned CC_LO     = 25;
  localparam int unsigned CC_SOLO   = 23;
  localparam int unsigned CC_PACK_W = CC_HI - CC_LO + 2;

  typedef logic [IDX_W-1:0] fcr_idx_t;

  localparam fcr_idx_t IDX_IMPL = 5'd0;
  localparam fcr_idx_t IDX_UFR  = 5'd1;
  localparam fcr_idx_t IDX_UNFR = 5'd4;
  localparam fcr_idx_t IDX_CCR  = 5'd25;

  typedef struct packed {
    logic rd_impl;
    logic rd_fr;
    logic rd_cc;
    logic fr_clr;
    logic fr_set;
    logic cc_wr;
    logic ri;
  } fcr_ctl_t;

endpackage

// File: rtl/fcr_rst_sync.sv
module fcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fcr_decode.sv
module fcr_decode
  import fcr_pkg::*;
(
  input  logic     op_valid,
  input  logic     op_write,
  input  fcr_idx_t op_index,
  input  logic     src_is_zero,
  input  logic     ufr_present,
  input  logic     ufr_enable,
  input  logic     wr_hi_zero,
  output fcr_ctl_t ctl
);

  logic is_rd, is_wr;
  logic hit_impl, hit_ufr, hit_unfr, hit_ccr;
  logic alias_rd, alias_wr;

  always_comb begin
    is_rd    = op_valid & ~op_write;
    is_wr    = op_valid &  op_write;
    hit_impl = (op_index == IDX_IMPL);
    hit_ufr  = (op_index == IDX_UFR);
    hit_unfr = (op_index == IDX_UNFR);
    hit_ccr  = (op_index == IDX_CCR);

    // Alias is live only when advertised; a write also needs a zero source.
    alias_rd = is_rd & hit_ufr & ufr_present;
    alias_wr = is_wr & (hit_ufr | hit_unfr) & ufr_present & src_is_zero;

    ctl         = '0;
    ctl.rd_impl = is_rd & hit_impl;
    ctl.rd_cc   = is_rd & hit_ccr;
    ctl.rd_fr   = alias_rd & ufr_enable;
    ctl.fr_clr  = alias_wr & ufr_enable & hit_ufr;
    ctl.fr_set  = alias_wr & ufr_enable & hit_unfr;
    ctl.cc_wr   = is_wr & hit_ccr & wr_hi_zero;
    ctl.ri      = (alias_rd | alias_wr) & ~ufr_enable;
  end

endmodule

// File: rtl/fcr_state.sv
module fcr_state
  import fcr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  fcr_ctl_t             ctl,
  input  logic [CC_PACK_W-1:0] cc_wdata,
  output logic                 fr_q,
  output logic [CC_PACK_W-1:0] cc_packed
);

  logic             fr_d, fr_en;
  logic [CSR_W-1:0] csr_q, csr_d;
  logic             csr_en;

  // Next-state logic
  always_comb begin
    fr_en = ctl.fr_clr | ctl.fr_set;
    fr_d  = ctl.fr_set & ~ctl.fr_clr;

    csr_en = ctl.cc_wr;
    csr_d  = csr_q;
    csr_d[CC_HI:CC_LO] = cc_wdata[CC_PACK_W-1:1];
    csr_d[CC_SOLO]     = cc_wdata[0];
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q  <= 1'b0;
      csr_q <= '0;
    end else begin
      if (fr_en)  fr_q  <= fr_d;
      if (csr_en) csr_q <= csr_d;
    end
  end

  assign cc_packed = {csr_q[CC_HI:CC_LO], csr_q[CC_SOLO]};

endmodule

// File: rtl/fcr_rdmux.sv
module fcr_rdmux
  import fcr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  fcr_ctl_t             ctl,
  input  logic [IMPL_W-1:0]    impl_reg,
  input  logic                 fr_q,
  input  logic [CC_PACK_W-1:0] cc_packed,
  output logic [XLEN-1:0]      rd_data
);

  logic [XLEN-1:0] impl_ext;

  generate
    if (XLEN > IMPL_W) begin : g_sext
      assign impl_ext = {{(XLEN-IMPL_W){impl_reg[IMPL_W-1]}}, impl_reg};
    end else begin : g_flat
      assign impl_ext = impl_reg[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (ctl.rd_impl) rd_data = impl_ext;
    if (ctl.rd_fr)   rd_data[0] = fr_q;
    if (ctl.rd_cc)   rd_data[CC_PACK_W-1:0] = cc_packed;
  end

endmodule

// File: rtl/fpu_ctrl_access.sv
module fpu_ctrl_access
  import fcr_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned UFRP_POS   = 28,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_write,
  input  logic [IDX_W-1:0]  op_index,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              src_is_zero,
  input  logic [IMPL_W-1:0] impl_reg,
  input  logic              ufr_enable,
  output logic [XLEN-1:0]   rd_data,
  output logic              ri_exc,
  output logic              fr_mode
);

  logic                 rst_sync_n;
  logic                 wr_hi_zero;
  fcr_ctl_t             ctl;
  logic                 fr_q;
  logic [CC_PACK_W-1:0] cc_packed;

  assign wr_hi_zero = ~|wr_data[XLEN-1:CC_PACK_W];

  fcr_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fcr_decode u_dec (
    .op_valid    (op_valid),
    .op_write    (op_write),
    .op_index    (op_index),
    .src_is_zero (src_is_zero),
    .ufr_present (impl_reg[UFRP_POS]),
    .ufr_enable  (ufr_enable),
    .wr_hi_zero  (wr_hi_zero),
    .ctl         (ctl)
  );

  fcr_state u_st (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl       (ctl),
    .cc_wdata  (wr_data[CC_PACK_W-1:0]),
    .fr_q      (fr_q),
    .cc_packed (cc_packed)
  );

  fcr_rdmux #(.XLEN(XLEN)) u_rd (
    .ctl       (ctl),
    .impl_reg  (impl_reg),
    .fr_q      (fr_q),
    .cc_packed (cc_packed),
    .rd_data   (rd_data)
  );

  assign ri_exc  = ctl.ri;
  assign fr_mode = fr_q;

endmodule

// File: rtl/fcr_access_chk.sv
module fcr_access_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_write,
  input logic [4:0]      op_index,
  input logic            src_is_zero,
  input logic            ufr_present,
  input logic            ufr_enable,
  input logic [XLEN-1:0] rd_data,
  input logic            ri_exc,
  input logic            fr_mode
);

  assert_fault_needs_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ri_exc |-> op_valid);

  assert_fr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && op_index == 5'd4 && ufr_present && src_is_zero && ufr_enable)
    |=> fr_mode);

  assert_fr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && op_index == 5'd1 && ufr_present && src_is_zero && ufr_enable)
    |=> !fr_mode);

  assert_fr_moves_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fr_mode) |-> $past(op_valid && op_write));

  assert_fault_keeps_fr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_exc && op_write) |=> $stable(fr_mode));

  assert_nonzero_src_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && !src_is_zero) |-> !ri_exc);

  assert_nonzero_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && !src_is_zero) |=> $stable(fr_mode));

  assert_absent_alias_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_write && op_index == 5'd1 && !ufr_present) |-> (rd_data == '0 && !ri_exc));

  assert_faulting_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_exc && !op_write) |-> rd_data == '0);

endmodule

bind fpu_ctrl_access fcr_access_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .op_valid    (op_valid),
  .op_write    (op_write),
  .op_index    (op_index),
  .src_is_zero (src_is_zero),
  .ufr_present (impl_reg[UFRP_POS]),
  .ufr_enable  (ufr_enable),
  .rd_data     (rd_data),
  .ri_exc      (ri_exc),
  .fr_mode     (fr_mode)
);

// File: tb/tb_fpu_ctrl_access.sv
module tb_fpu_ctrl_access;

  localparam int unsigned XLEN = 64;
  localparam logic [31:0] IA = 32'h9000_1234;  // bit 28 set, bit 31 set
  localparam logic [31:0] IN = 32'h0000_5678;  // bit 28 clear

  logic            clk = 1'b0;
  logic            rst_n;
  logic            op_valid, op_write, src_is_zero, ufr_enable;
  logic [4:0]      op_index;
  logic [XLEN-1:0] wr_data;
  logic [31:0]     impl_reg;
  logic [XLEN-1:0] rd_data;
  logic            ri_exc, fr_mode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fpu_ctrl_access #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_write(op_write),
    .op_index(op_index), .wr_data(wr_data), .src_is_zero(src_is_zero),
    .impl_reg(impl_reg), .ufr_enable(ufr_enable), .rd_data(rd_data),
    .ri_exc(ri_exc), .fr_mode(fr_mode)
  );

  typedef struct packed {
    logic        w;
    logic [4:0]  idx;
    logic [63:0] data;
    logic        src0;
    logic [31:0] impl;
    logic        en;
    logic [63:0] exp_rd;
    logic        exp_exc;
    logic        exp_fr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0,  64'h0,  1'b1, IA, 1'b1, 64'hFFFF_FFFF_9000_1234, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 5'd0,  64'h0,  1'b1, IN, 1'b1, 64'h5678, 1'b0, 1'b0, 4'd2},                 // R2
    '{1'b0, 5'd1,  64'h0,  1'b1, IA, 1'b1, 64'h0, 1'b0, 1'b0, 4'd3},                    // R3
    '{1'b1, 5'd4,  64'h0,  1'b1, IA, 1'b1, 64'h0, 1'b0, 1'b1, 4'd6},                    // R6
    '{1'b0, 5'd1,  64'h0,  1'b1, IA, 1'b1, 64'h1, 1'b0, 1'b1, 4'd3},                    // R3
    '{1'b0, 5'd1,  64'h0,  1'b1, IA, 1'b0, 64'h0, 1'b1, 1'b1, 4'd4},                    // R4
    '{1'b0, 5'd1,  64'h0,  1'b1, IN, 1'b0, 64'h0, 1'b0, 1'b1, 4'd5},                    // R5
    '{1'b1, 5'd1,  64'h0,  1'b0, IA, 1'b1, 64'h0, 1'b0, 1'b1, 4'd7},                    // R7
    '{1'b1, 5'd1,  64'h0,  1'b1, IN, 1'b1, 64'h0, 1'b0, 1'b1, 4'd7},                    // R7
    '{1'b1, 5'd1,  64'h0,  1'b1, IA, 1'b0, 64'h0, 1'b1, 1'b1, 4'd8},                    // R8
    '{1'b1, 5'd1,  64'h0,  1'b1, IA, 1'b1, 64'h0, 1'b0, 1'b0, 4'd6},                    // R6
    '{1'b1, 5'd4,  64'h0,  1'b1, IA, 1'b0, 64'h0, 1'b1, 1'b0, 4'd8},                    // R8
    '{1'b1, 5'd4,  64'h0,  1'b0, IA, 1'b0, 64'h0, 1'b0, 1'b0, 4'd7},                    // R7
    '{1'b1, 5'd25, 64'hA5, 1'b1, IA, 1'b1, 64'h0, 1'b0, 1'b0, 4'd10},                   // R10
    '{1'b0, 5'd25, 64'h0,  1'b1, IA, 1'b1, 64'hA5, 1'b0, 1'b0, 4'd9},                   // R9
    '{1'b1, 5'd25, 64'h1FF, 1'b1, IA, 1'b1, 64'h0, 1'b0, 1'b0, 4'd11},                  // R11
    '{1'b0, 5'd25, 64'h0,  1'b1, IA, 1'b1, 64'hA5, 1'b0, 1'b0, 4'd11},                  // R11
    '{1'b1, 5'd25, 64'h1_0000_0000, 1'b1, IA, 1'b1, 64'h0, 1'b0, 1'b0, 4'd11},          // R11
    '{1'b0, 5'd25, 64'h0,  1'b1, IA, 1'b1, 64'hA5, 1'b0, 1'b0, 4'd11},                  // R11
    '{1'b1, 5'd7,  64'h3C, 1'b1, IA, 1'b0, 64'h0, 1'b0, 1'b0, 4'd12},                   // R12
    '{1'b0, 5'd7,  64'h0,  1'b1, IA, 1'b0, 64'h0, 1'b0, 1'b0, 4'd12},                   // R12
    '{1'b0, 5'd25, 64'h0,  1'b1, IA, 1'b1, 64'hA5, 1'b0, 1'b0, 4'd12},                  // R12
    '{1'b1, 5'd25, 64'h5A, 1'b1, IA, 1'b1, 64'h0, 1'b0, 1'b0, 4'd10},                   // R10
    '{1'b0, 5'd25, 64'h0,  1'b1, IA, 1'b1, 64'h5A, 1'b0, 1'b0, 4'd9}                    // R9
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Drive at a falling edge, sample combinational results 1 ns later,
  // then sample fr_mode just after the next falling edge.
  task automatic do_op(input logic w, input logic [4:0] idx, input logic [63:0] d,
                       input logic s0, input logic [31:0] im, input logic en, input logic vld,
                       output logic [63:0] rd, output logic exc, output logic fr);
    @(negedge clk);
    op_valid = vld; op_write = w; op_index = idx; wr_data = d;
    src_is_zero = s0; impl_reg = im; ufr_enable = en;
    #1;
    rd = rd_data; exc = ri_exc;
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    fr = fr_mode;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic        exc, fr;
    rst_n = 1'b0; op_valid = 1'b0; op_write = 1'b0; op_index = '0; wr_data = '0;
    src_is_zero = 1'b0; impl_reg = IA; ufr_enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 fr_mode in reset", {63'd0, fr_mode}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: state after reset
    do_op(1'b0, 5'd25, 64'h0, 1'b1, IA, 1'b1, 1'b1, rd, exc, fr);
    chk("R1 cc word after reset", rd, 64'h0);
    chk("R1 fr_mode after reset", {63'd0, fr}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].w, VECS[i].idx, VECS[i].data, VECS[i].src0, VECS[i].impl, VECS[i].en,
            1'b1, rd, exc, fr);
      chk($sformatf("R%0d vec%0d rd_data", VECS[i].req, i), rd, VECS[i].exp_rd);
      chk($sformatf("R%0d vec%0d ri_exc", VECS[i].req, i), {63'd0, exc}, {63'd0, VECS[i].exp_exc});
      chk($sformatf("R%0d vec%0d fr_mode", VECS[i].req, i), {63'd0, fr}, {63'd0, VECS[i].exp_fr});
    end

    // R13: no strobe -> no fault, no data, no state change
    do_op(1'b1, 5'd4, 64'h0, 1'b1, IA, 1'b0, 1'b0, rd, exc, fr);
    chk("R13 no fault without strobe", {63'd0, exc}, 64'd0);
    chk("R13 fr unchanged without strobe", {63'd0, fr}, 64'd0);
    do_op(1'b1, 5'd4, 64'h0, 1'b1, IA, 1'b1, 1'b0, rd, exc, fr);
    chk("R13 fr not set without strobe", {63'd0, fr}, 64'd0);
    do_op(1'b0, 5'd0, 64'h0, 1'b1, IA, 1'b1, 1'b0, rd, exc, fr);
    chk("R13 rd_data zero without strobe", rd, 64'h0);

    // R6: set FR and load the word, then R1: reset clears both
    do_op(1'b1, 5'd4, 64'h0, 1'b1, IA, 1'b1, 1'b1, rd, exc, fr);
    chk("R6 fr set before reset", {63'd0, fr}, 64'd1);
    do_op(1'b1, 5'd25, 64'hFF, 1'b1, IA, 1'b1, 1'b1, rd, exc, fr);
    do_op(1'b0, 5'd25, 64'h0, 1'b1, IA, 1'b1, 1'b1, rd, exc, fr);
    chk("R10 full cc load", rd, 64'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears fr_mode", {63'd0, fr_mode}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_op(1'b0, 5'd25, 64'h0, 1'b1, IA, 1'b1, 1'b1, rd, exc, fr);
    chk("R1 cc word cleared by reset", rd, 64'h0);
    do_op(1'b0, 5'd1, 64'h0, 1'b1, IA, 1'b1, 1'b1, rd, exc, fr);
    chk("R3 alias read after reset", rd, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule